// File: doc/BRIEF.md
# Multi-Bank Busy and Access Checker

This block sits between the host bus and a sixteen-bank flash array. It records which bank an embedded program or erase is running in. For every host access it decides, in the same cycle, whether the access may go ahead. The bank is taken from the top four address bits. A read aimed at a bank that is not busy goes to the array with no added wait. A read aimed at the busy bank is steered to status data.

Host writes carry a command: program, sector erase or whole-device erase. A granted command starts tracking at the next clock edge. Only one embedded operation runs at a time. A completion pulse from the algorithm engine releases the operation. A sector erase can be suspended. While it is suspended, its bank is open to reads and to one nested program anywhere outside the sector being erased. A resume makes the bank busy again. Sector boundaries follow the array layout. The lowest 64 Kword of bank 0 and the highest 64 Kword of bank 15 are each split into four 16 Kword boot sectors. Every other sector is 64 Kword.

Top module: `flash_bank_guard`

## Requirements
- R1: The bank index is `acc_addr[21:18]`. Once a granted command has taken effect, `busy_bank` reports the bank of the command that is running.
- R2: A read (`acc_valid`=1, `acc_write`=0) is always granted in the same cycle. It gives `rd_status_sel`=0 when its bank is not busy and it does not fall in a suspended erase sector.
- R3: A read aimed at a bank whose `busy_mask` bit is set gives `rd_status_sel`=1.
- R4: With no operation running or suspended, a write with `acc_cmd` 0 (program), 1 (sector erase) or 2 (whole-device erase) is granted in the same cycle. From the next cycle, `busy_valid`=1. Code 3 is always blocked.
- R5: Any write issued while an operation is running is blocked (`acc_block`=1). It leaves the busy state unchanged.
- R6: A whole-device erase sets all sixteen `busy_mask` bits. Every read then selects status.
- R7: `op_done` while an operation runs and no erase is suspended clears `busy_valid` and `busy_mask` on the next cycle.
- R8: `susp_req` during a sector erase clears `busy_mask` and sets `erase_suspended` on the next cycle. Reads then go to the array, except reads inside the suspended sector. `susp_req` during a program or a whole-device erase is ignored.
- R9: While an erase is suspended, a program (code 0) outside the suspended sector is granted and makes its bank busy. Its `op_done` returns the block to the suspended state. Erase commands are blocked while an erase is suspended.
- R10: A program aimed at the suspended sector is blocked, and `susp_conflict`=1 in that same cycle.
- R11: Boot sectors are 16 Kword. They occupy bank 0 offsets 0x00000–0x0FFFF and bank 15 offsets 0x30000–0x3FFFF. All other sectors are 64 Kword aligned.
- R12: `resume_req` while suspended, with no write granted in the same cycle, makes the erase bank busy again on the next cycle. A granted write takes priority over a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = command write, 0 = read |
| acc_cmd | input | 2 | Write command: 0 program, 1 sector erase, 2 whole-device erase, 3 reserved |
| acc_addr | input | 22 | Word address of the access |
| op_done | input | 1 | Embedded operation finished (pulse) |
| susp_req | input | 1 | Suspend the running sector erase |
| resume_req | input | 1 | Resume the suspended erase |
| acc_grant | output | 1 | Access may proceed |
| acc_block | output | 1 | Access is rejected |
| rd_status_sel | output | 1 | Read returns status instead of array data |
| susp_conflict | output | 1 | Program rejected because it targets the suspended sector |
| busy_valid | output | 1 | An embedded operation is actively running |
| busy_bank | output | 4 | Bank of the running operation |
| busy_mask | output | 16 | One bit per bank that is busy |
| erase_suspended | output | 1 | A sector erase is suspended |

## Verification
The checker watches the following on every cycle:
- Reads are never blocked, and grant and block never overlap.
- `busy_mask` is either empty, one-hot, or full.
- A read into a busy bank selects status.
- A granted write leads to a busy state.
- A conflict flag always comes with a block inside a suspension.
- Suspend, resume and completion events move the busy state in the required direction.

The bench scenarios show the rest:
- The exact bank and sector arithmetic, including the boot-sector boundaries in banks 0 and 15.
- The nesting order of program inside a suspended erase, and the return to suspension afterwards.
- That ignored suspends and rejected commands leave the visible busy state unchanged.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;

  typedef enum logic [1:0] {
    CMD_PROG       = 2'd0,
    CMD_SECT_ERASE = 2'd1,
    CMD_CHIP_ERASE = 2'd2,
    CMD_RSVD       = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RUN       = 2'd1,
    ST_SUSP      = 2'd2,
    ST_SUSP_PROG = 2'd3
  } trk_state_e;

endpackage

// File: rtl/bank_sector_decode.sv
module bank_sector_decode #(
  parameter int AW        = 22,
  parameter int BANK_BITS = 4,
  parameter int BIG_BITS  = 16,
  parameter int BOOT_BITS = 14
) (
  input  logic [AW-1:0]        addr,
  output logic [BANK_BITS-1:0] bank,
  output logic [AW-1:0]        sect_base
);
  localparam int OFS_BITS = AW - BANK_BITS;
  localparam int UP_BITS  = OFS_BITS - BIG_BITS;
  localparam logic [BANK_BITS-1:0] LAST_BANK = {BANK_BITS{1'b1}};

  function automatic logic in_boot(input logic [AW-1:0] a);
    logic [BANK_BITS-1:0] b;
    logic [UP_BITS-1:0]   up;
    b  = a[AW-1 -: BANK_BITS];
    up = a[OFS_BITS-1:BIG_BITS];
    return ((b == '0) && (up == '0)) || ((b == LAST_BANK) && (&up));
  endfunction

  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a);
    logic [AW-1:0] m;
    if (in_boot(a)) m = {{(AW-BOOT_BITS){1'b1}}, {BOOT_BITS{1'b0}}};
    else            m = {{(AW-BIG_BITS){1'b1}},  {BIG_BITS{1'b0}}};
    return a & m;
  endfunction

  assign bank      = addr[AW-1 -: BANK_BITS];
  assign sect_base = base_of(addr);
endmodule

// File: rtl/op_tracker.sv
module op_tracker
  import flash_bank_pkg::*;
#(
  parameter int AW        = 22,
  parameter int BANK_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_evt,
  input  cmd_e                 start_cmd,
  input  logic [BANK_BITS-1:0] start_bank,
  input  logic [AW-1:0]        start_base,
  input  logic                 done_evt,
  input  logic                 susp_evt,
  input  logic                 resume_evt,
  output trk_state_e           state,
  output cmd_e                 act_cmd,
  output logic [BANK_BITS-1:0] act_bank,
  output logic [AW-1:0]        erase_base
);
  logic [BANK_BITS-1:0] erase_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      act_cmd    <= CMD_PROG;
      act_bank   <= '0;
      erase_base <= '0;
      erase_bank <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_evt) begin
          state    <= ST_RUN;
          act_cmd  <= start_cmd;
          act_bank <= start_bank;
          if (start_cmd == CMD_SECT_ERASE) begin
            erase_base <= start_base;
            erase_bank <= start_bank;
          end
        end
        ST_RUN: begin
          if (done_evt)      state <= ST_IDLE;
          else if (susp_evt) state <= ST_SUSP;
        end
        ST_SUSP: begin
          if (start_evt) begin
            state    <= ST_SUSP_PROG;
            act_cmd  <= CMD_PROG;
            act_bank <= start_bank;
          end else if (resume_evt) begin
            state <= ST_RUN;
          end
        end
        ST_SUSP_PROG: if (done_evt) begin
          state    <= ST_SUSP;
          act_cmd  <= CMD_SECT_ERASE;
          act_bank <= erase_bank;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/access_arbiter.sv
module access_arbiter
  import flash_bank_pkg::*;
#(
  parameter int AW        = 22,
  parameter int BANK_BITS = 4
) (
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  cmd_e                      acc_cmd,
  input  logic [BANK_BITS-1:0]      acc_bank,
  input  logic [AW-1:0]             acc_base,
  input  trk_state_e                state,
  input  logic [AW-1:0]             erase_base,
  input  logic [(1<<BANK_BITS)-1:0] busy_mask,
  output logic                      grant,
  output logic                      block,
  output logic                      status_sel,
  output logic                      conflict
);
  logic is_rd, is_wr, in_susp, hit_susp_sect, wr_ok;

  function automatic logic write_allowed(input trk_state_e st, input cmd_e c,
                                         input logic same_sect);
    if (st == ST_IDLE) return c != CMD_RSVD;
    if (st == ST_SUSP) return (c == CMD_PROG) && !same_sect;
    return 1'b0;
  endfunction

  always_comb begin
    is_rd         = acc_valid && !acc_write;
    is_wr         = acc_valid && acc_write;
    in_susp       = (state == ST_SUSP) || (state == ST_SUSP_PROG);
    hit_susp_sect = in_susp && (acc_base == erase_base);
    wr_ok         = write_allowed(state, acc_cmd, hit_susp_sect);
    grant         = is_rd || (is_wr && wr_ok);
    block         = acc_valid && !grant;
    status_sel    = is_rd && (busy_mask[acc_bank] || hit_susp_sect);
    conflict      = is_wr && (state == ST_SUSP) && (acc_cmd == CMD_PROG) && hit_susp_sect;
  end
endmodule

// File: rtl/flash_bank_guard.sv
module flash_bank_guard
  import flash_bank_pkg::*;
#(
  parameter int AW        = 22,
  parameter int BANK_BITS = 4,
  parameter int BIG_BITS  = 16,
  parameter int BOOT_BITS = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [1:0]                acc_cmd,
  input  logic [AW-1:0]             acc_addr,
  input  logic                      op_done,
  input  logic                      susp_req,
  input  logic                      resume_req,
  output logic                      acc_grant,
  output logic                      acc_block,
  output logic                      rd_status_sel,
  output logic                      susp_conflict,
  output logic                      busy_valid,
  output logic [BANK_BITS-1:0]      busy_bank,
  output logic [(1<<BANK_BITS)-1:0] busy_mask,
  output logic                      erase_suspended
);
  localparam int NBANK = 1 << BANK_BITS;

  logic [BANK_BITS-1:0] dec_bank;
  logic [AW-1:0]        dec_base;
  logic [AW-1:0]        erase_base;
  trk_state_e           state;
  cmd_e                 act_cmd;
  cmd_e                 cmd_in;
  logic                 start_evt, done_evt, susp_evt, resume_evt;

  assign cmd_in = cmd_e'(acc_cmd);

  bank_sector_decode #(.AW(AW), .BANK_BITS(BANK_BITS), .BIG_BITS(BIG_BITS),
                       .BOOT_BITS(BOOT_BITS)) u_dec (
    .addr(acc_addr), .bank(dec_bank), .sect_base(dec_base));

  assign start_evt  = acc_valid && acc_write && acc_grant;
  assign done_evt   = op_done && ((state == ST_RUN) || (state == ST_SUSP_PROG));
  assign susp_evt   = susp_req && (state == ST_RUN) && (act_cmd == CMD_SECT_ERASE) && !op_done;
  assign resume_evt = resume_req && (state == ST_SUSP) && !start_evt;

  op_tracker #(.AW(AW), .BANK_BITS(BANK_BITS)) u_trk (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .start_cmd(cmd_in),
    .start_bank(dec_bank), .start_base(dec_base), .done_evt(done_evt),
    .susp_evt(susp_evt), .resume_evt(resume_evt), .state(state),
    .act_cmd(act_cmd), .act_bank(busy_bank), .erase_base(erase_base));

  assign busy_valid      = (state == ST_RUN) || (state == ST_SUSP_PROG);
  assign erase_suspended = (state == ST_SUSP) || (state == ST_SUSP_PROG);

  for (genvar i = 0; i < NBANK; i++) begin : g_mask
    assign busy_mask[i] = busy_valid &&
                          ((act_cmd == CMD_CHIP_ERASE) || (busy_bank == BANK_BITS'(i)));
  end

  access_arbiter #(.AW(AW), .BANK_BITS(BANK_BITS)) u_arb (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_cmd(cmd_in),
    .acc_bank(dec_bank), .acc_base(dec_base), .state(state),
    .erase_base(erase_base), .busy_mask(busy_mask), .grant(acc_grant),
    .block(acc_block), .status_sel(rd_status_sel), .conflict(susp_conflict));
endmodule

// File: rtl/flash_bank_guard_chk.sv
module flash_bank_guard_chk #(
  parameter int AW        = 22,
  parameter int BANK_BITS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_valid,
  input logic                      acc_write,
  input logic [AW-1:0]             acc_addr,
  input logic                      acc_grant,
  input logic                      acc_block,
  input logic                      rd_status_sel,
  input logic                      susp_conflict,
  input logic                      op_done,
  input logic                      busy_valid,
  input logic [(1<<BANK_BITS)-1:0] busy_mask,
  input logic                      erase_suspended,
  input logic                      start_evt,
  input logic                      susp_evt,
  input logic                      resume_evt
);
  p_read_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> acc_grant);

  p_grant_block_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && acc_block));

  p_start_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !busy_valid);

  p_busy_read_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && busy_mask[acc_addr[AW-1 -: BANK_BITS]]) |-> rd_status_sel);

  p_write_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_grant) |=> busy_valid);

  p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(busy_mask) || (&busy_mask)));

  p_done_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && busy_valid && !erase_suspended) |=> !busy_valid);

  p_susp_reopens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |=> (erase_suspended && (busy_mask == '0)));

  p_conflict_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    susp_conflict |-> (acc_block && erase_suspended));

  p_resume_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> (busy_valid && !erase_suspended));
endmodule

bind flash_bank_guard flash_bank_guard_chk #(.AW(AW), .BANK_BITS(BANK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_grant(acc_grant), .acc_block(acc_block),
  .rd_status_sel(rd_status_sel), .susp_conflict(susp_conflict), .op_done(op_done),
  .busy_valid(busy_valid), .busy_mask(busy_mask), .erase_suspended(erase_suspended),
  .start_evt(start_evt), .susp_evt(susp_evt), .resume_evt(resume_evt));

// File: tb/sim_flash_bank_guard.sv
module sim_flash_bank_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_cmd = 2'd0;
  logic [21:0] acc_addr = '0;
  logic        op_done = 1'b0, susp_req = 1'b0, resume_req = 1'b0;
  logic        acc_grant, acc_block, rd_status_sel, susp_conflict, busy_valid, erase_suspended;
  logic [3:0]  busy_bank;
  logic [15:0] busy_mask;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  flash_bank_guard u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_cmd(acc_cmd), .acc_addr(acc_addr), .op_done(op_done), .susp_req(susp_req),
    .resume_req(resume_req), .acc_grant(acc_grant), .acc_block(acc_block),
    .rd_status_sel(rd_status_sel), .susp_conflict(susp_conflict),
    .busy_valid(busy_valid), .busy_bank(busy_bank), .busy_mask(busy_mask),
    .erase_suspended(erase_suspended));

  typedef struct packed {
    logic [7:0]  req;
    logic        v, w;
    logic [1:0]  cmd;
    logic [21:0] addr;
    logic        done, susp, res;
    logic        e_grant, e_stat, e_conf, e_bv;
    logic [15:0] e_mask;
    logic [3:0]  e_bank;
  } vec_t;

  localparam int NV = 32;
  // cmd codes: 0 program, 1 sector erase, 2 whole-device erase, 3 reserved
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1,0,2'd0,{4'd3,18'h00000},0,0,0, 1,0,0,0,16'h0000,4'd0}, // R2 read, idle
    '{8'd1,  1,1,2'd1,{4'd5,18'h20000},0,0,0, 1,0,0,1,16'h0020,4'd5}, // R1 R4 sector erase bank5
    '{8'd3,  1,0,2'd0,{4'd5,18'h00123},0,0,0, 1,1,0,1,16'h0020,4'd5}, // R3 read busy bank
    '{8'd2,  1,0,2'd0,{4'd6,18'h00000},0,0,0, 1,0,0,1,16'h0020,4'd5}, // R2 read other bank
    '{8'd5,  1,1,2'd0,{4'd6,18'h00000},0,0,0, 0,0,0,1,16'h0020,4'd5}, // R5 program while busy
    '{8'd8,  0,0,2'd0,22'h0,              0,1,0, 0,0,0,0,16'h0000,4'd5}, // R8 suspend
    '{8'd8,  1,0,2'd0,{4'd5,18'h00000},0,0,0, 1,0,0,0,16'h0000,4'd5}, // R8 read other sector
    '{8'd8,  1,0,2'd0,{4'd5,18'h20010},0,0,0, 1,1,0,0,16'h0000,4'd5}, // R8 read suspended sector
    '{8'd10, 1,1,2'd0,{4'd5,18'h2ABCD},0,0,0, 0,0,1,0,16'h0000,4'd5}, // R10 conflict
    '{8'd9,  1,1,2'd1,{4'd1,18'h00000},0,0,0, 0,0,0,0,16'h0000,4'd5}, // R9 erase blocked in suspend
    '{8'd9,  1,1,2'd0,{4'd5,18'h30000},0,0,0, 1,0,0,1,16'h0020,4'd5}, // R9 nested program
    '{8'd3,  1,0,2'd0,{4'd5,18'h00010},0,0,0, 1,1,0,1,16'h0020,4'd5}, // R3 read during nested program
    '{8'd9,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd5}, // R9 done -> suspended
    '{8'd12, 0,0,2'd0,22'h0,              0,0,1, 0,0,0,1,16'h0020,4'd5}, // R12 resume
    '{8'd7,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd5}, // R7 done
    '{8'd6,  1,1,2'd2,{4'd0,18'h00000},0,0,0, 1,0,0,1,16'hFFFF,4'd0}, // R6 whole-device erase
    '{8'd6,  1,0,2'd0,{4'd9,18'h11111},0,0,0, 1,1,0,1,16'hFFFF,4'd0}, // R6 read status
    '{8'd8,  0,0,2'd0,22'h0,              0,1,0, 0,0,0,1,16'hFFFF,4'd0}, // R8 suspend ignored
    '{8'd7,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd0}, // R7 done
    '{8'd11, 1,1,2'd1,{4'd0,18'h04000},0,0,0, 1,0,0,1,16'h0001,4'd0}, // R11 boot sector 1 erase
    '{8'd8,  0,0,2'd0,22'h0,              0,1,0, 0,0,0,0,16'h0000,4'd0}, // R8 suspend
    '{8'd11, 1,1,2'd0,{4'd0,18'h00100},0,0,0, 1,0,0,1,16'h0001,4'd0}, // R11 boot sector 0 program ok
    '{8'd9,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd0}, // R9 back to suspend
    '{8'd11, 1,1,2'd0,{4'd0,18'h07FFF},0,0,0, 0,0,1,0,16'h0000,4'd0}, // R11 R10 same boot sector
    '{8'd12, 1,1,2'd0,{4'd2,18'h00000},0,0,1, 1,0,0,1,16'h0004,4'd2}, // R12 write wins over resume
    '{8'd9,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd0}, // R9 done -> suspend
    '{8'd12, 0,0,2'd0,22'h0,              0,0,1, 0,0,0,1,16'h0001,4'd0}, // R12 resume
    '{8'd7,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd0}, // R7 done
    '{8'd4,  1,1,2'd3,{4'd2,18'h00000},0,0,0, 0,0,0,0,16'h0000,4'd0}, // R4 reserved code blocked
    '{8'd8,  1,1,2'd0,{4'd7,18'h00000},0,0,0, 1,0,0,1,16'h0080,4'd7}, // R8 program bank7
    '{8'd8,  0,0,2'd0,22'h0,              0,1,0, 0,0,0,1,16'h0080,4'd7}, // R8 suspend of program ignored
    '{8'd7,  0,0,2'd0,22'h0,              1,0,0, 0,0,0,0,16'h0000,4'd7}  // R7 done
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; acc_write = 0; acc_cmd = 0; acc_addr = '0;
    op_done = 0; susp_req = 0; resume_req = 0;
  endtask

  initial begin
    #80000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    if (!finished) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R7 reset state: nothing busy
    chk("reset busy_valid", 7, 32'(busy_valid), 0);
    chk("reset mask", 7, 32'(busy_mask), 0);
    chk("reset suspended", 8, 32'(erase_suspended), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = VEC[i].v; acc_write = VEC[i].w; acc_cmd = VEC[i].cmd;
      acc_addr = VEC[i].addr; op_done = VEC[i].done; susp_req = VEC[i].susp;
      resume_req = VEC[i].res;
      #1;
      chk("grant", int'(VEC[i].req), 32'(acc_grant), 32'(VEC[i].e_grant));
      chk("block", int'(VEC[i].req), 32'(acc_block), 32'(VEC[i].v && !VEC[i].e_grant));
      chk("status_sel", int'(VEC[i].req), 32'(rd_status_sel), 32'(VEC[i].e_stat));
      chk("conflict", int'(VEC[i].req), 32'(susp_conflict), 32'(VEC[i].e_conf));
      @(posedge clk); #1;
      chk("busy_valid", int'(VEC[i].req), 32'(busy_valid), 32'(VEC[i].e_bv));
      chk("busy_mask", int'(VEC[i].req), 32'(busy_mask), 32'(VEC[i].e_mask));
      if (VEC[i].e_bv) chk("busy_bank", int'(VEC[i].req), 32'(busy_bank), 32'(VEC[i].e_bank));
      idle_inputs();
    end

    // R4 R1 directed: erase in bank 15 boot region, then reset mid-operation
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_cmd = 2'd1; acc_addr = {4'd15, 18'h3C000};
    @(posedge clk); #1; idle_inputs();
    chk("bank15 busy_bank", 1, 32'(busy_bank), 15);
    @(negedge clk); susp_req = 1;
    @(posedge clk); #1; idle_inputs();
    // R11 bank15 boot sectors: 0x38000 is a different 16 Kword sector
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_cmd = 2'd0; acc_addr = {4'd15, 18'h38000}; #1;
    chk("bank15 other boot sector grant", 11, 32'(acc_grant), 1);
    acc_addr = {4'd15, 18'h3FFFF}; #1;
    chk("bank15 same boot sector conflict", 11, 32'(susp_conflict), 1);
    idle_inputs();
    @(negedge clk); rst_n = 0; #1;
    chk("async reset clears suspend", 8, 32'(erase_suspended), 0);
    chk("async reset clears mask", 7, 32'(busy_mask), 0);
    @(negedge clk); rst_n = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule